// File: doc/BRIEF.md
# Message-Signalled Interrupt Aggregator

This block gathers message-signalled interrupts (MSI) that PCIe endpoints post as writes to one inbound target register. Each write names a vector number. The block spreads the vectors over a set of status groups in an interleaved order. Vector `v` lands in group `v mod 8` at bit position `v >> 3`, so group 0 collects vectors 0, 8, 16 and 24. Every group has a pending-status register that software clears by writing ones. It also has an enable mask with separate set and clear addresses, and its own interrupt output towards the host interrupt controller.

Each group output fires once when an enabled bit is pending. It stays quiet until software writes the group's index to a shared end-of-interrupt register. Four legacy INTx level inputs are handled the same way, with a single-bit status and enable each. They share the same end-of-interrupt register and use the low index values. Software reaches everything through a plain 32-bit register bus: byte address, write strobe, write data, and read data registered one cycle later.

Top module: `msi_intx_aggregator`

## Requirements
- R1: A bus write to address 0x054 with data `v` in the range 0..31 sets status bit `v >> 3` of group `v mod 8`. Group `n` status reads back at 0x104 + 0x10*n in bits 3:0, and bits 31:4 read as zero.
- R2: A write to 0x054 with data of 32 or more changes no status bit.
- R3: Writing to a group status address clears each status bit whose data bit is one. Bits written with zero are kept.
- R4: Writing to 0x108 + 0x10*n sets the enable bits given by ones in the data. Writing to 0x10C + 0x10*n clears them. Both addresses read back the current enable mask of group `n`.
- R5: `msi_irq[n]` is high for exactly one cycle, starting on the second clock edge after the bus write that made (status & enable) of an armed group nonzero. A pending bit that is not enabled raises no output.
- R6: After group `n` fires it stays low, even while its bits remain pending, until data n+4 is written to 0x050. That write re-arms the group, and a group that is still pending fires again two edges later.
- R7: Writes to 0x050 with any other value leave the group disarmed; this includes legacy indices 0..3 and other group indices.
- R8: Legacy line `i`: a high on `intx_in[i]` sets status bit 0 at 0x184 + 0x10*i. Enable set and clear sit at 0x188 + 0x10*i and 0x18C + 0x10*i. `intx_irq[i]` follows the same one-pulse and re-arm rules as R5 and R6, with end-of-interrupt value `i`.
- R9: Synchronous active-high reset clears all status and enable bits, arms every group and line, and drives all interrupt outputs and `bus_rdata` to zero.
- R10: `bus_rdata` shows, one edge later, the register at the address presented while `bus_we` is low. Unmapped addresses, 0x050 and 0x054 read as zero.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 12 | Register byte address |
| bus_we | input | 1 | Write strobe, one write per asserted cycle |
| bus_wdata | input | 32 | Write data |
| intx_in | input | 4 | Legacy INTx level inputs |
| bus_rdata | output | 32 | Registered read data |
| msi_irq | output | 8 | One interrupt pulse line per MSI group |
| intx_irq | output | 4 | One interrupt pulse line per legacy line |

## Verification
The bench posts vectors that differ in their low three bits and in their upper two bits. Reading several groups back then separates the interleaved mapping from a blocked one, and out-of-range vector numbers show whether they wrap into a group. Interrupt outputs are exercised in four orders: pending before enable, enable before pending, end-of-interrupt with the bit still pending, and end-of-interrupt after the bit was cleared. These four orders separate level behaviour from one-shot behaviour and show whether re-arming depends on pending state. End-of-interrupt writes with wrong indices, including legacy ones, check that the index decode picks only its own group. A legacy line is pulsed both enabled and disabled.

// File: rtl/msi_agg_pkg.sv
package msi_agg_pkg;
  localparam int EOI_ADDR      = 'h050;
  localparam int MSI_TGT_ADDR  = 'h054;
  localparam int MSI_STAT_BASE = 'h104;
  localparam int INTX_STAT_BASE = 'h184;
  localparam int REG_STRIDE    = 'h10;
  localparam int EN_SET_OFS    = 'h4;
  localparam int EN_CLR_OFS    = 'h8;
endpackage

// File: rtl/irq_slice.sv
module irq_slice #(
  parameter int W = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] set_i,
  input  logic         stat_clr_we,
  input  logic         en_set_we,
  input  logic         en_clr_we,
  input  logic [W-1:0] wbits,
  input  logic         eoi_i,
  output logic [W-1:0] status_o,
  output logic [W-1:0] enable_o,
  output logic         irq_o
);
  logic [W-1:0] status_q, enable_q;
  logic         armed_q, irq_q, fire;

  assign fire = armed_q & (|(status_q & enable_q));

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= '0;
      enable_q <= '0;
      armed_q  <= 1'b1;
      irq_q    <= 1'b0;
    end else begin
      // a new arrival wins over a clear in the same cycle
      status_q <= (status_q & ~(stat_clr_we ? wbits : '0)) | set_i;
      if (en_set_we)
        enable_q <= enable_q | wbits;
      else if (en_clr_we)
        enable_q <= enable_q & ~wbits;
      irq_q <= fire;
      if (eoi_i)
        armed_q <= 1'b1;
      else if (fire)
        armed_q <= 1'b0;
    end
  end

  assign status_o = status_q;
  assign enable_o = enable_q;
  assign irq_o    = irq_q;
endmodule

// File: rtl/msi_intx_aggregator.sv
module msi_intx_aggregator #(
  parameter int ADDR_W     = 12,
  parameter int DATA_W     = 32,
  parameter int N_GROUPS   = 8,
  parameter int GROUP_BITS = 4,
  parameter int N_INTX     = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic [ADDR_W-1:0]   bus_addr,
  input  logic                bus_we,
  input  logic [DATA_W-1:0]   bus_wdata,
  input  logic [N_INTX-1:0]   intx_in,
  output logic [DATA_W-1:0]   bus_rdata,
  output logic [N_GROUPS-1:0] msi_irq,
  output logic [N_INTX-1:0]   intx_irq
);
  import msi_agg_pkg::*;

  localparam int N_VEC = N_GROUPS * GROUP_BITS;
  localparam int VEC_W = $clog2(N_VEC);

  logic                  msi_hit, eoi_hit;
  logic [GROUP_BITS-1:0] msi_stat [N_GROUPS];
  logic [GROUP_BITS-1:0] msi_en   [N_GROUPS];
  logic [N_INTX-1:0]     intx_stat, intx_en;
  logic [DATA_W-1:0]     rd_next, rdata_q;

  assign msi_hit = bus_we && (bus_addr == ADDR_W'(MSI_TGT_ADDR))
                   && (bus_wdata[DATA_W-1:VEC_W] == '0);
  assign eoi_hit = bus_we && (bus_addr == ADDR_W'(EOI_ADDR));

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_msi
    localparam int BASE = MSI_STAT_BASE + REG_STRIDE * g;
    logic [GROUP_BITS-1:0] set_v;
    for (genvar b = 0; b < GROUP_BITS; b++) begin : g_bit
      assign set_v[b] = msi_hit && (bus_wdata[VEC_W-1:0] == VEC_W'(g + N_GROUPS * b));
    end
    irq_slice #(.W(GROUP_BITS)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .set_i       (set_v),
      .stat_clr_we (bus_we && bus_addr == ADDR_W'(BASE)),
      .en_set_we   (bus_we && bus_addr == ADDR_W'(BASE + EN_SET_OFS)),
      .en_clr_we   (bus_we && bus_addr == ADDR_W'(BASE + EN_CLR_OFS)),
      .wbits       (bus_wdata[GROUP_BITS-1:0]),
      .eoi_i       (eoi_hit && bus_wdata == DATA_W'(N_INTX + g)),
      .status_o    (msi_stat[g]),
      .enable_o    (msi_en[g]),
      .irq_o       (msi_irq[g])
    );
  end

  for (genvar i = 0; i < N_INTX; i++) begin : g_intx
    localparam int BASE = INTX_STAT_BASE + REG_STRIDE * i;
    irq_slice #(.W(1)) u_slice (
      .clk         (clk),
      .rst         (rst),
      .set_i       (intx_in[i]),
      .stat_clr_we (bus_we && bus_addr == ADDR_W'(BASE)),
      .en_set_we   (bus_we && bus_addr == ADDR_W'(BASE + EN_SET_OFS)),
      .en_clr_we   (bus_we && bus_addr == ADDR_W'(BASE + EN_CLR_OFS)),
      .wbits       (bus_wdata[0]),
      .eoi_i       (eoi_hit && bus_wdata == DATA_W'(i)),
      .status_o    (intx_stat[i]),
      .enable_o    (intx_en[i]),
      .irq_o       (intx_irq[i])
    );
  end

  always_comb begin
    rd_next = '0;
    for (int g = 0; g < N_GROUPS; g++) begin
      if (bus_addr == ADDR_W'(MSI_STAT_BASE + REG_STRIDE * g))
        rd_next = DATA_W'(msi_stat[g]);
      if (bus_addr == ADDR_W'(MSI_STAT_BASE + REG_STRIDE * g + EN_SET_OFS) ||
          bus_addr == ADDR_W'(MSI_STAT_BASE + REG_STRIDE * g + EN_CLR_OFS))
        rd_next = DATA_W'(msi_en[g]);
    end
    for (int i = 0; i < N_INTX; i++) begin
      if (bus_addr == ADDR_W'(INTX_STAT_BASE + REG_STRIDE * i))
        rd_next = DATA_W'(intx_stat[i]);
      if (bus_addr == ADDR_W'(INTX_STAT_BASE + REG_STRIDE * i + EN_SET_OFS) ||
          bus_addr == ADDR_W'(INTX_STAT_BASE + REG_STRIDE * i + EN_CLR_OFS))
        rd_next = DATA_W'(intx_en[i]);
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdata_q <= '0;
    else
      rdata_q <= rd_next;
  end

  assign bus_rdata = rdata_q;
endmodule

// File: rtl/msi_agg_checker.sv
module msi_agg_checker #(
  parameter int ADDR_W   = 12,
  parameter int DATA_W   = 32,
  parameter int N_GROUPS = 8,
  parameter int N_INTX   = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [ADDR_W-1:0]   bus_addr,
  input logic                bus_we,
  input logic [DATA_W-1:0]   bus_wdata,
  input logic [DATA_W-1:0]   bus_rdata,
  input logic [N_GROUPS-1:0] msi_irq,
  input logic [N_INTX-1:0]   intx_irq
);
  import msi_agg_pkg::*;

  logic [N_GROUPS-1:0] wait_eoi;

  for (genvar g = 0; g < N_GROUPS; g++) begin : g_chk
    logic eoi_seen;
    assign eoi_seen = bus_we && bus_addr == ADDR_W'(EOI_ADDR)
                      && bus_wdata == DATA_W'(N_INTX + g);

    always_ff @(posedge clk) begin
      if (rst)
        wait_eoi[g] <= 1'b0;
      else if (eoi_seen)
        wait_eoi[g] <= 1'b0;
      else if (msi_irq[g])
        wait_eoi[g] <= 1'b1;
    end

    p_msi_pulse_r5: assert property (@(posedge clk) disable iff (rst)
      msi_irq[g] |=> !msi_irq[g]);

    p_no_refire_r6: assert property (@(posedge clk) disable iff (rst)
      wait_eoi[g] |-> !msi_irq[g]);
  end

  for (genvar i = 0; i < N_INTX; i++) begin : g_ichk
    p_intx_pulse_r8: assert property (@(posedge clk) disable iff (rst)
      intx_irq[i] |=> !intx_irq[i]);
  end

  p_reset_quiet_r9: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (msi_irq == '0 && intx_irq == '0 && bus_rdata == '0));
endmodule

bind msi_intx_aggregator msi_agg_checker #(
  .ADDR_W(ADDR_W), .DATA_W(DATA_W), .N_GROUPS(N_GROUPS), .N_INTX(N_INTX)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_addr  (bus_addr),
  .bus_we    (bus_we),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .msi_irq   (msi_irq),
  .intx_irq  (intx_irq)
);

// File: tb/msi_intx_aggregator_bench.sv
module msi_intx_aggregator_bench;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [11:0] bus_addr = '0;
  logic        bus_we = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [3:0]  intx_in = '0;
  logic [31:0] bus_rdata;
  logic [7:0]  msi_irq;
  logic [3:0]  intx_irq;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  logic [31:0] due_e[$];
  string       due_t[$];

  always #(CLK_PERIOD/2) clk = ~clk;

  msi_intx_aggregator u_msi_intx_aggregator (
    .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_we(bus_we),
    .bus_wdata(bus_wdata), .intx_in(intx_in), .bus_rdata(bus_rdata),
    .msi_irq(msi_irq), .intx_irq(intx_irq)
  );

  // scoreboard monitor: a read issued before an edge is due at the next negedge
  always @(posedge clk) begin
    while (exp_q.size() > 0) begin
      due_e.push_back(exp_q.pop_front());
      due_t.push_back(tag_q.pop_front());
    end
  end

  always @(negedge clk) begin
    if (due_e.size() > 0) begin
      logic [31:0] e;
      string t;
      e = due_e.pop_front();
      t = due_t.pop_front();
      checks++;
      if (bus_rdata !== e) begin
        errors++;
        $display("FAIL %s: rdata actual %h expected %h", t, bus_rdata, e);
      end
    end
  end

  task automatic chk(input logic [31:0] act, input logic [31:0] exp, input string t);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", t, act, exp);
    end
  endtask

  task automatic tick();
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic wr(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_addr = a; bus_wdata = d; bus_we = 1'b1;
  endtask

  task automatic rd(input logic [11:0] a, input logic [31:0] e, input string t);
    @(negedge clk);
    bus_we = 1'b0; bus_addr = a;
    exp_q.push_back(e); tag_q.push_back(t);
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual running expected finished");
      finish_run();
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    tick();
    // R9 reset state
    chk(32'(msi_irq), 0, "R9 msi_irq after reset");
    chk(32'(intx_irq), 0, "R9 intx_irq after reset");
    chk(bus_rdata, 0, "R9 rdata after reset");
    rd(12'h104, 0, "R9 group0 status");
    rd(12'h158, 0, "R9 group5 enable");
    rd(12'h184, 0, "R9 intx0 status");

    // R1 interleaved mapping
    wr(12'h054, 13);
    wr(12'h054, 24);
    wr(12'h054, 7);
    wr(12'h054, 31);
    rd(12'h154, 32'h2, "R1 vector 13 -> group5 bit1");
    rd(12'h104, 32'h8, "R1 vector 24 -> group0 bit3");
    rd(12'h174, 32'h9, "R1 vectors 7,31 -> group7");
    rd(12'h114, 32'h0, "R1 group1 untouched");

    // R2 out-of-range vectors
    wr(12'h054, 32);
    wr(12'h054, 37);
    wr(12'h054, 32'h100);
    rd(12'h104, 32'h8, "R2 group0 unchanged");
    rd(12'h154, 32'h2, "R2 group5 unchanged");
    rd(12'h144, 32'h0, "R2 group4 unchanged");

    // R3 write-one-to-clear
    wr(12'h174, 0);
    rd(12'h174, 32'h9, "R3 zero write keeps bits");
    wr(12'h174, 1);
    rd(12'h174, 32'h8, "R3 one clears only bit0");

    // R4 enable set/clear
    wr(12'h128, 5);
    rd(12'h128, 5, "R4 set addr readback");
    rd(12'h12C, 5, "R4 clr addr readback");
    wr(12'h12C, 4);
    rd(12'h128, 1, "R4 after clear");
    wr(12'h128, 2);
    rd(12'h12C, 3, "R4 after second set");

    // R5 pending but disabled gives nothing; enabling fires once
    tick();
    chk(32'(msi_irq), 0, "R5 disabled pending stays quiet");
    wr(12'h158, 2);
    tick(); chk(32'(msi_irq), 0, "R5 not yet");
    tick(); chk(32'(msi_irq), 32'h20, "R5 group5 fires");
    tick(); chk(32'(msi_irq), 0, "R5 single pulse");

    // R6 no refire until EOI, then refire while pending
    tick(); tick();
    chk(32'(msi_irq), 0, "R6 held off while pending");
    wr(12'h050, 9);
    tick();
    tick(); chk(32'(msi_irq), 32'h20, "R6 refire after EOI");
    tick(); chk(32'(msi_irq), 0, "R6 refire is a pulse");
    wr(12'h154, 2);
    wr(12'h050, 9);
    tick();
    tick(); chk(32'(msi_irq), 0, "R6 EOI with nothing pending");
    tick(); chk(32'(msi_irq), 0, "R6 still quiet");

    // R7 wrong EOI indices do not re-arm
    wr(12'h054, 21);
    tick();
    tick(); chk(32'(msi_irq), 0, "R7 vector 21 not enabled");
    wr(12'h158, 4);
    tick();
    tick(); chk(32'(msi_irq), 32'h20, "R7 group5 fires on bit2");
    wr(12'h050, 3);
    wr(12'h050, 8);
    tick();
    tick(); chk(32'(msi_irq), 0, "R7 EOI 3 and 8 leave group5 disarmed");
    wr(12'h050, 9);
    tick();
    tick(); chk(32'(msi_irq), 32'h20, "R7 correct EOI re-arms");

    // R8 legacy line 2 enabled
    wr(12'h1A8, 1);
    tick(); intx_in = 4'b0100;
    tick(); intx_in = 4'b0000;
    tick(); chk(32'(intx_irq), 32'h4, "R8 intx2 fires");
    tick(); chk(32'(intx_irq), 0, "R8 intx2 pulse");
    rd(12'h1A4, 1, "R8 intx2 status");
    wr(12'h1A4, 1);
    rd(12'h1A4, 0, "R8 intx2 cleared");
    wr(12'h050, 2);
    tick();
    tick(); chk(32'(intx_irq), 0, "R8 EOI without pending");
    tick(); intx_in = 4'b0100;
    tick(); intx_in = 4'b0000;
    tick(); chk(32'(intx_irq), 32'h4, "R8 intx2 fires again after EOI");
    // legacy line 0 not enabled
    tick(); intx_in = 4'b0001;
    tick(); intx_in = 4'b0000;
    tick(); chk(32'(intx_irq), 0, "R8 intx0 disabled");
    rd(12'h184, 1, "R8 intx0 status latched");
    rd(12'h188, 0, "R8 intx0 enable");
    rd(12'h1AC, 1, "R8 intx2 enable via clr addr");

    // R10 unmapped and write-only addresses
    rd(12'h060, 0, "R10 unmapped read");
    rd(12'h054, 0, "R10 target reads zero");
    rd(12'h050, 0, "R10 EOI reads zero");
    tick(); tick();

    done = 1'b1;
    finish_run();
  end
endmodule